// File: doc/BRIEF.md
# Prioritized Modem Interrupt Controller

This block collects four single-cycle event pulses from a radio modem (receive finished, receive begun, transmit finished and modem ready) and turns them into one active-high interrupt request for a microcontroller. Each pulse sets a sticky pending flag. A flag is recorded whether or not its source is enabled. The interrupt line is raised when any pending flag has its enable bit set.

Software sees three byte-wide registers on a simple read/write bus. The first holds the pending flags. The second holds the per-source enable mask, which can be read and written. The third holds a small code that names the highest-priority source that is both pending and enabled. A read of either the pending register or the code register clears every pending flag at once. An event that arrives in the same cycle as that clearing read is kept, so it is not lost.

Top module: `modem_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all pending flags, sets the enable mask to 4'b1111, and drives irq and bus_rdata to 0.
- R2: The event vector maps bit 0 to receive-end, bit 1 to receive-start, bit 2 to transmit-end and bit 3 to modem-ready. A one-cycle pulse on bit i sets pending flag i, which reads back in bit i of the status register at offset 0.
- R3: Pulses on several sources in one cycle, or in separate cycles, leave all of the matching pending flags set together.
- R4: A pending flag is recorded even when its enable bit is 0.
- R5: Offset 1 holds the enable mask in bits [3:0] and reads 0 in bits [7:4]. A write to offset 0 or offset 2 changes neither the mask nor the pending flags.
- R6: irq is high exactly when (pending AND enable) is nonzero. It updates on the same clock edge as the flags and the mask that it depends on.
- R7: A read at offset 2 returns the code of the highest-priority source that is both pending and enabled: 1 for receive-end, 2 for receive-start, 3 for transmit-end and 4 for modem-ready, with priority in that order. It returns 0 when no enabled source is pending, and bits [7:3] read 0.
- R8: A read at offset 0 or offset 2 returns the value held before the read and clears every pending flag. A read at offset 1 clears nothing.
- R9: An event pulse in the same cycle as a clearing read leaves its flag set after that read.
- R10: bus_rdata is registered. It takes the read value on the clock edge that samples bus_rd and holds it while no read is made. Offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 4 | Event pulses: [0] rx end, [1] rx start, [2] tx end, [3] ready |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every result here is due one clock edge after its stimulus. A pulse or a mask write on edge N changes irq at edge N. A read strobe sampled on edge N puts its data on bus_rdata at edge N and clears the flags on that same edge, so the new flags show only in a read sampled on a later edge. The bench drives every input on the falling edge. It lets exactly one rising edge pass, and then compares irq and bus_rdata on the next falling edge against a cycle model. That model computes the read value from the state before the edge and the flags and mask from the state after it.

// File: rtl/modem_irq_pkg.sv
package modem_irq_pkg;
  parameter int NUM_SRC = 4;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 2;
  localparam int IDX_W  = $clog2(NUM_SRC + 1);

  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_IDX  = ADDR_W'(2);

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [IDX_W-1:0]   idx_t;
endpackage

// File: rtl/modem_irq_latch.sv
module modem_irq_latch
  import modem_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t evt,
  input  logic     clr_all,
  output src_vec_t sts_d,
  output src_vec_t sts_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    // new event beats a simultaneous clear
    assign sts_d[g] = evt[g] | (sts_q[g] & ~clr_all);

    always_ff @(posedge clk) begin
      if (rst) sts_q[g] <= 1'b0;
      else     sts_q[g] <= sts_d[g];
    end
  end
endmodule

// File: rtl/modem_irq_prio.sv
module modem_irq_prio
  import modem_irq_pkg::*;
(
  input  src_vec_t pend,
  output idx_t     code
);
  // bit 0 wins; scan from lowest priority so higher ones override
  always_comb begin
    code = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) code = IDX_W'(i + 1);
    end
  end
endmodule

// File: rtl/modem_irq_regs.sv
module modem_irq_regs
  import modem_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  src_vec_t          sts_q,
  input  idx_t              idx_code,
  output src_vec_t          en_d,
  output src_vec_t          en_q,
  output logic              clr_all,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:NUM_SRC];

  assign clr_all = bus_rd & ((bus_addr == OFF_STAT) | (bus_addr == OFF_IDX));
  assign en_d    = (bus_wr && bus_addr == OFF_MASK) ? bus_wdata[NUM_SRC-1:0] : en_q;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_STAT: rd_mux = DATA_W'(sts_q);
      OFF_MASK: rd_mux = DATA_W'(en_q);
      OFF_IDX:  rd_mux = DATA_W'(idx_code);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '1;
      rdata_q <= '0;
    end else begin
      en_q <= en_d;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
  import modem_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  src_vec_t sts_d, sts_q, en_d, en_q;
  logic     clr_all;
  idx_t     idx_code;
  logic     irq_q;

  modem_irq_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_pulse),
    .clr_all (clr_all),
    .sts_d   (sts_d),
    .sts_q   (sts_q)
  );

  modem_irq_prio u_prio (
    .pend (sts_q & en_q),
    .code (idx_code)
  );

  modem_irq_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sts_q     (sts_q),
    .idx_code  (idx_code),
    .en_d      (en_d),
    .en_q      (en_q),
    .clr_all   (clr_all),
    .bus_rdata (bus_rdata)
  );

  // registered from next state so irq moves on the same edge as flags
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_d & en_d);
  end

  assign irq = irq_q;
endmodule

// File: rtl/modem_irq_chk.sv
module modem_irq_chk
  import modem_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input src_vec_t          sts_q,
  input src_vec_t          en_q
);
  logic clr_rd;
  assign clr_rd = bus_rd && (bus_addr == OFF_STAT || bus_addr == OFF_IDX);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sts_q == '0 && en_q == '1 && !irq && bus_rdata == '0));

  assert_event_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((sts_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (|(sts_q & en_q)));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_IDX) |=> (bus_rdata <= DATA_W'(NUM_SRC)));

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && evt_pulse == '0) |=> (sts_q == '0));

  assert_no_spurious_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !clr_rd |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_event_survives_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && evt_pulse != '0) |=> (sts_q == $past(evt_pulse)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind modem_irq_ctrl modem_irq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_pulse (evt_pulse),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .sts_q     (sts_q),
  .en_q      (en_q)
);

// File: tb/modem_irq_ctrl_tb.sv
`timescale 1ns/1ps
module modem_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] evt_pulse;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_sts, m_en;
  logic [7:0] m_rd;
  logic       m_irq;

  always #2 clk = ~clk;

  modem_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [2:0] prio_code(input logic [3:0] p);
    if (p[0]) return 3'd1;
    if (p[1]) return 3'd2;
    if (p[2]) return 3'd3;
    if (p[3]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [7:0] read_val(input logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_sts};
      2'd1: return {4'b0, m_en};
      2'd2: return {5'b0, prio_code(m_sts & m_en)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, lets one rising edge pass, checks at next falling edge
  task automatic step(input logic [3:0] ev, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [7:0] wd, input string tag);
    evt_pulse = ev; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    if (rd) m_rd = read_val(a);
    if (rd && (a == 2'd0 || a == 2'd2)) m_sts = ev;
    else m_sts = m_sts | ev;
    if (wr && a == 2'd1) m_en = wd[3:0];
    m_irq = |(m_sts & m_en);
    @(posedge clk);
    @(negedge clk);
    evt_pulse = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    compare(bus_rdata, m_rd, tag);
    compare({7'b0, irq}, {7'b0, m_irq}, "R6 irq");
  endtask

  task automatic idle(input string tag);
    step(4'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; evt_pulse = '0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_sts = '0; m_en = 4'hF; m_rd = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    compare(bus_rdata, 8'h00, "R1 rdata");
    compare({7'b0, irq}, 8'h00, "R1 irq");
    rst = 1'b0;

    step(4'b0, 1, 0, 2'd1, 0, "R1 enable reset");
    step(4'b0, 1, 0, 2'd0, 0, "R1 status reset");

    // R2 each source alone, with index code
    for (int i = 0; i < 4; i++) begin
      step(4'b1 << i, 0, 0, 2'd0, 0, "R2 pulse");
      step(4'b0, 1, 0, 2'd0, 0, "R2 status bit");
      step(4'b1 << i, 0, 0, 2'd0, 0, "R7 pulse");
      step(4'b0, 1, 0, 2'd2, 0, "R7 single code");
    end

    // R3 together and apart
    step(4'b1111, 0, 0, 2'd0, 0, "R3 all");
    step(4'b0, 1, 0, 2'd0, 0, "R3 all read");
    step(4'b0010, 0, 0, 2'd0, 0, "R3 a");
    step(4'b1000, 0, 0, 2'd0, 0, "R3 b");
    step(4'b0, 1, 0, 2'd0, 0, "R3 apart read");

    // R4 masked sources still latch
    step(4'b0, 0, 1, 2'd1, 8'h00, "R4 mask all");
    step(4'b0100, 0, 0, 2'd0, 0, "R4 pulse masked");
    step(4'b0, 1, 0, 2'd2, 0, "R4 index zero when masked");
    step(4'b0100, 0, 0, 2'd0, 0, "R4 pulse masked");
    step(4'b0, 1, 0, 2'd0, 0, "R4 status latched");

    // R5 mask access, upper bits, writes elsewhere ignored
    step(4'b0, 0, 1, 2'd1, 8'hA5, "R5 write");
    step(4'b0, 1, 0, 2'd1, 0, "R5 readback");
    step(4'b0, 0, 1, 2'd0, 8'hFF, "R5 wr off0");
    step(4'b0, 0, 1, 2'd2, 8'hFF, "R5 wr off2");
    step(4'b0, 1, 0, 2'd1, 0, "R5 mask unchanged");
    step(4'b0, 1, 0, 2'd0, 0, "R5 status unchanged");

    // R6 irq tracks mask changes on pending flags
    step(4'b0010, 0, 0, 2'd0, 0, "R6 pend masked");
    step(4'b0, 0, 1, 2'd1, 8'h02, "R6 unmask raises");
    step(4'b0, 0, 1, 2'd1, 8'h00, "R6 mask lowers");

    // R7 priority with masking
    step(4'b0, 0, 1, 2'd1, 8'h0F, "R7 mask all on");
    step(4'b1110, 0, 0, 2'd0, 0, "R7 three");
    step(4'b0, 1, 0, 2'd2, 0, "R7 rx start wins");
    step(4'b0, 0, 1, 2'd1, 8'h0D, "R7 mask bit1");
    step(4'b1111, 0, 0, 2'd0, 0, "R7 all");
    step(4'b0, 0, 1, 2'd1, 8'h0C, "R7 mask bit0,1");
    step(4'b0, 1, 0, 2'd2, 0, "R7 tx end wins");

    // R8 read of mask does not clear; status read clears
    step(4'b0, 0, 1, 2'd1, 8'h0F, "R8 mask on");
    step(4'b0101, 0, 0, 2'd0, 0, "R8 pulse");
    step(4'b0, 1, 0, 2'd1, 0, "R8 mask read");
    step(4'b0, 1, 0, 2'd0, 0, "R8 status read");
    step(4'b0, 1, 0, 2'd0, 0, "R8 cleared");
    step(4'b1000, 0, 0, 2'd0, 0, "R8 pulse");
    step(4'b0, 1, 0, 2'd2, 0, "R8 index read");
    step(4'b0, 1, 0, 2'd0, 0, "R8 index cleared");

    // R9 event during clearing read
    step(4'b0001, 0, 0, 2'd0, 0, "R9 pre");
    step(4'b0100, 1, 0, 2'd0, 0, "R9 race read");
    step(4'b0, 1, 0, 2'd0, 0, "R9 survived");
    step(4'b0010, 1, 0, 2'd2, 0, "R9 race idx");
    step(4'b0, 1, 0, 2'd0, 0, "R9 survived idx");

    // R10 offset 3 and hold
    step(4'b0011, 1, 0, 2'd3, 0, "R10 offset3");
    idle("R10 hold");
    step(4'b0, 1, 0, 2'd0, 0, "R10 after");
    idle("R10 hold");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ev;
      logic       rd, wr;
      logic [1:0] a;
      logic [7:0] wd;
      string      tg;
      ev = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
      rd = ($urandom % 3 == 0);
      wr = ($urandom % 8 == 0);
      a  = 2'($urandom);
      wd = 8'($urandom);
      case (a)
        2'd0: tg = "R8 rand status";
        2'd1: tg = "R5 rand mask";
        2'd2: tg = "R7 rand index";
        default: tg = "R10 rand";
      endcase
      step(ev, rd, wr, a, wd, tg);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule